// File: doc/BRIEF.md
# External Interrupt Capture with Filtered Timer Event

This block turns four asynchronous interrupt pins into pending flags and a single prioritised request. Each pin goes through a two-stage synchroniser. The last pin also passes through a sampled noise filter whose rate is selectable. A per-source 2-bit trigger code decides what counts as a hit:

- The two lower sources accept a rising edge, a falling edge, a high level or a low level.
- The two upper sources accept a rising edge, a falling edge or both edges.

A hit sets the source's pending flag when the source is enabled. The flag is cleared by a one-cycle pulse on the source's clear input.

The request output reports whether any enabled flag is pending. The vector output gives the fixed entry address of the lowest-numbered enabled pending source. The two upper sources also drive a one-cycle event strobe toward an external timer counter. That strobe fires on every qualified edge, whether or not the source is enabled.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released with all pins low, irq_o, vec_o and tmr_evt_o are all zero.
- R2: A pin change held across clock edges produces its timer strobe after the third rising clock edge following the change, and its request after the fourth.
- R3: For sources 0 and 1, mode field mode_i[2i+1:2i] selects the trigger: 00 rising edge, 01 falling edge, 10 high level, 11 low level.
- R4: For sources 2 and 3, the mode field selects the trigger: 00 rising edge, 01 falling edge, 10 or 11 both edges.
- R5: A level-triggered flag stays set while its level persists, even with clr_i asserted. Once the level has gone, a clear removes the flag.
- R6: An edge-set flag stays set until a cycle with clr_i[i] high removes it. If a new qualified edge and the clear act in the same cycle, the flag stays set.
- R7: A source with en_i[i] low never sets its flag and raises no request. Enabling it later reveals no flag from hits seen while it was disabled.
- R8: When several enabled flags are pending, the lowest index wins. vec_o is 8'h03, 8'h0B, 8'h13 or 8'h1B for sources 0 to 3.
- R9: On sources 0 to 2, a pin pulse lasting one clock cycle is detected.
- R10: The source 3 filter samples every cycle, every 16th cycle or every 64th cycle for fsel_i of 00, 01 or 1x. It changes level after two consecutive agreeing samples, so it accepts pulses of 2, 32 or 128 cycles and rejects pulses of 1, 15 or 63 cycles.
- R11: tmr_evt_o[0] (source 2) and tmr_evt_o[1] (source 3) pulse for one cycle on every qualified edge of that source's mode, regardless of en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw interrupt pins, asynchronous |
| mode_i | input | 8 | Trigger code, 2 bits per source, source i at bits 2i+1:2i |
| en_i | input | 4 | Per-source enable |
| fsel_i | input | 2 | Source 3 filter sampling-rate select |
| clr_i | input | 4 | Per-source pending clear, one cycle |
| irq_o | output | 1 | Any enabled source pending |
| vec_o | output | 8 | Vector of the winning source |
| tmr_evt_o | output | 2 | Timer event strobes for sources 2 and 3 |

## Verification
Two functions collide in the same cycle: the CPU clear and a fresh qualified hit landing on the same flag. The collision arises for a new edge and for a level that is still active. The bench provokes the edge case by toggling a both-edge pin and placing the clear pulse exactly in the cycle where the registered event is present, three edges after the pin change. It provokes the level case by holding clear while the level stays asserted. In both cases the request and vector must persist, both in the behavioural model compared every clock and in explicit point checks. A randomised phase then mixes pins, clears, modes and filter rates so that such coincidences also occur unplanned.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    FSEL_FULL = 2'b00,
    FSEL_MID  = 2'b01,
    FSEL_SLOW = 2'b10
  } fsel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter
  import ext_irq_pkg::*;
#(
  parameter int MID_LOG  = 4,
  parameter int SLOW_LOG = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] fsel_i,
  input  logic       din_i,
  output logic       dout_o
);
  localparam int CNT_W = SLOW_LOG;
  localparam logic [CNT_W-1:0] MASK_MID  = CNT_W'((1 << MID_LOG) - 1);
  localparam logic [CNT_W-1:0] MASK_SLOW = CNT_W'((1 << SLOW_LOG) - 1);

  logic [CNT_W-1:0] cnt_q, mask;
  logic             strobe, smp_q, filt_q;

  always_comb begin
    case (fsel_e'(fsel_i))
      FSEL_FULL: mask = '0;
      FSEL_MID:  mask = MASK_MID;
      default:   mask = MASK_SLOW;
    endcase
  end

  assign strobe = (cnt_q & mask) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      smp_q  <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (strobe) begin
        smp_q <= din_i;
        // two agreeing samples against the held level
        if (din_i == smp_q && din_i != filt_q) filt_q <= din_i;
      end
    end
  end

  assign dout_o = filt_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       evt_o
);
  logic lvl_d_q, evt_q, rise, fall, hit;

  assign rise = lvl_i & ~lvl_d_q;
  assign fall = ~lvl_i & lvl_d_q;

  generate
    if (LEVEL_OK) begin : g_lvl
      always_comb begin
        case (trig_e'(mode_i))
          TRIG_RISE: hit = rise;
          TRIG_FALL: hit = fall;
          TRIG_HIGH: hit = lvl_i;
          default:   hit = ~lvl_i;
        endcase
      end
    end else begin : g_edge
      always_comb begin
        if (mode_i[1])      hit = rise | fall;
        else if (mode_i[0]) hit = fall;
        else                hit = rise;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      lvl_d_q <= lvl_i;
      evt_q   <= hit;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int N    = 4,
  parameter int VW   = 8,
  parameter int BASE = 3,
  parameter int STEP = 8
) (
  input  logic [N-1:0]  act_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    irq_o = |act_i;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) vec_o = VW'(BASE + STEP * i);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_SRC       = 4,
  parameter int LEVEL_SRCS    = 2,
  parameter int VEC_W         = 8,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STEP      = 8,
  parameter int FILT_MID_LOG  = 4,
  parameter int FILT_SLOW_LOG = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            pin_i,
  input  logic [2*NUM_SRC-1:0]          mode_i,
  input  logic [NUM_SRC-1:0]            en_i,
  input  logic [1:0]                    fsel_i,
  input  logic [NUM_SRC-1:0]            clr_i,
  output logic                          irq_o,
  output logic [VEC_W-1:0]              vec_o,
  output logic [NUM_SRC-LEVEL_SRCS-1:0] tmr_evt_o
);
  localparam int FILT_IDX = NUM_SRC - 1;

  logic [NUM_SRC-1:0] sync_q, lvl, evt_q, pend_q;
  logic               filt_lvl;

  ext_irq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  ext_irq_filter #(
    .MID_LOG (FILT_MID_LOG),
    .SLOW_LOG(FILT_SLOW_LOG)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fsel_i(fsel_i),
    .din_i (sync_q[FILT_IDX]),
    .dout_o(filt_lvl)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g == FILT_IDX) begin : g_f
        assign lvl[g] = filt_lvl;
      end else begin : g_s
        assign lvl[g] = sync_q[g];
      end

      ext_irq_detect #(.LEVEL_OK(g < LEVEL_SRCS)) u_det (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (lvl[g]),
        .mode_i(mode_i[2*g+:2]),
        .evt_o (evt_q[g])
      );
    end
  endgenerate

  // new hit outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (evt_q & en_i) | (pend_q & ~clr_i);
  end

  ext_irq_prio #(
    .N   (NUM_SRC),
    .VW  (VEC_W),
    .BASE(VEC_BASE),
    .STEP(VEC_STEP)
  ) u_prio (
    .act_i(pend_q & en_i),
    .irq_o(irq_o),
    .vec_o(vec_o)
  );

  assign tmr_evt_o = evt_q[NUM_SRC-1:LEVEL_SRCS];
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NUM_SRC    = 4,
  parameter int LEVEL_SRCS = 2,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_SRC-1:0]            en_i,
  input logic [NUM_SRC-1:0]            clr_i,
  input logic                          irq_o,
  input logic [VEC_W-1:0]              vec_o,
  input logic [NUM_SRC-LEVEL_SRCS-1:0] tmr_evt_o,
  input logic [NUM_SRC-1:0]            evt_q,
  input logic [NUM_SRC-1:0]            pend_q
);
  localparam int TOP_EVT = NUM_SRC - LEVEL_SRCS - 1;
  localparam logic [2:0] VEC_LOW = 3'(VEC_BASE);

  p_vec_form_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vec_o[2:0] == VEC_LOW);

  p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & en_i) == '0) |-> !irq_o);

  p_req_follows_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $stable(en_i)) |-> $past(evt_q != '0));

  p_filt_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_o[TOP_EVT] |=> !tmr_evt_o[TOP_EVT]);

  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_k
      p_hit_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_q[k] && en_i[k]) |=> pend_q[k]);
      p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[k] && !clr_i[k]) |=> pend_q[k]);
    end
  endgenerate
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .NUM_SRC   (NUM_SRC),
  .LEVEL_SRCS(LEVEL_SRCS),
  .VEC_W     (VEC_W),
  .VEC_BASE  (VEC_BASE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .clr_i    (clr_i),
  .irq_o    (irq_o),
  .vec_o    (vec_o),
  .tmr_evt_o(tmr_evt_o),
  .evt_q    (evt_q),
  .pend_q   (pend_q)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0;
  logic [7:0] mode = '0;
  logic [3:0] en = 4'hF;
  logic [1:0] fsel = '0;
  logic [3:0] clr = '0;
  logic       irq;
  logic [7:0] vec;
  logic [1:0] tmr;

  int    n_vec = 0;
  int    n_bad = 0;
  int    evt_cnt2 = 0;
  int    evt_cnt3 = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pin_i    (pin),
    .mode_i   (mode),
    .en_i     (en),
    .fsel_i   (fsel),
    .clr_i    (clr),
    .irq_o    (irq),
    .vec_o    (vec),
    .tmr_evt_o(tmr)
  );

  // behavioural reference
  bit [3:0] m_s1, m_s2, m_lvld, m_evt, m_pend, m_lv, m_ne;
  bit       m_smp, m_filt, m_strobe;
  int       m_cnt, m_div;

  function automatic bit trig(int i, bit [1:0] md, bit l, bit ld);
    bit r, f;
    r = l & ~ld;
    f = ~l & ld;
    if (i < 2) begin
      case (md)
        2'd0: return r;
        2'd1: return f;
        2'd2: return l;
        default: return ~l;
      endcase
    end
    if (md[1]) return r | f;
    return md[0] ? f : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_lvld = '0; m_evt = '0; m_pend = '0;
      m_smp = 0; m_filt = 0; m_cnt = 0;
    end else begin
      m_lv = {m_filt, m_s2[2:0]};
      m_pend = (m_evt & en) | (m_pend & ~clr);
      for (int i = 0; i < 4; i++) m_ne[i] = trig(i, mode[2*i+:2], m_lv[i], m_lvld[i]);
      m_evt = m_ne;
      m_lvld = m_lv;
      m_div = (fsel == 2'b00) ? 1 : (fsel == 2'b01) ? 16 : 64;
      m_strobe = (m_cnt % m_div) == 0;
      m_cnt++;
      if (m_strobe) begin
        if (m_s2[3] == m_smp && m_s2[3] != m_filt) m_filt = m_s2[3];
        m_smp = m_s2[3];
      end
      m_s2 = m_s1;
      m_s1 = pin;
    end
  end

  function automatic bit [7:0] exp_vec(bit [3:0] act);
    for (int i = 0; i < 4; i++) if (act[i]) return 8'(3 + 8 * i);
    return 8'h00;
  endfunction

  // compare a quarter period after each rising edge
  always @(posedge clk) begin
    bit [3:0] act;
    #5;
    act = m_pend & en;
    n_vec++;
    if (irq !== (|act) || vec !== exp_vec(act) || tmr !== m_evt[3:2]) begin
      n_bad++;
      $display("FAIL %s model: irq/vec/tmr act=%b/%h/%b exp=%b/%h/%b",
               cur_req, irq, vec, tmr, |act, exp_vec(act), m_evt[3:2]);
    end
    if (tmr[0] === 1'b1) evt_cnt2++;
    if (tmr[1] === 1'b1) evt_cnt3++;
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s point: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic filt_case(bit [1:0] fs, int width, int exp_n);
    cur_req = "R10";
    fsel = fs;
    cyc(140);
    evt_cnt3 = 0;
    pin[3] = 1'b1;
    cyc(width);
    pin[3] = 1'b0;
    cyc(300);
    check("R10", 8'(evt_cnt3), 8'(exp_n));
    clr[3] = 1'b1;
    cyc(1);
    clr[3] = 1'b0;
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    check("R1", {7'd0, irq}, 8'h00);
    check("R1", {6'd0, tmr}, 8'h00);
    rst_n = 1'b1;
    cyc(4);
    check("R1", {irq, vec[6:0]}, 8'h00);

    // R2, R3: rising edge on source 0, latency
    cur_req = "R2";
    pin[0] = 1'b1;
    repeat (3) @(posedge clk);
    #5 check("R2", {7'd0, irq}, 8'h00);
    @(posedge clk);
    #5 check("R2", {irq, vec[6:0]}, 8'h83);
    cyc(2);
    cur_req = "R6";
    clr[0] = 1'b1;
    cyc(1);
    clr[0] = 1'b0;
    cyc(1);
    check("R6", {7'd0, irq}, 8'h00);

    // R3, R9: falling trigger on source 1 with a one-cycle pulse
    cur_req = "R9";
    mode[3:2] = 2'b01;
    pin[1] = 1'b1;
    cyc(1);
    pin[1] = 1'b0;
    cyc(6);
    check("R9", vec, 8'h0B);
    clr[1] = 1'b1;
    cyc(1);
    clr[1] = 1'b0;
    cyc(2);

    // R5: high level on source 0 held against clear
    cur_req = "R5";
    mode[1:0] = 2'b10;
    cyc(5);
    check("R5", vec, 8'h03);
    clr[0] = 1'b1;
    cyc(4);
    check("R5", {irq, vec[6:0]}, 8'h83);
    clr[0] = 1'b0;
    pin[0] = 1'b0;
    cyc(5);
    check("R5", {irq, vec[6:0]}, 8'h83);
    clr[0] = 1'b1;
    cyc(1);
    clr[0] = 1'b0;
    cyc(1);
    check("R5", {7'd0, irq}, 8'h00);
    mode[1:0] = 2'b00;

    // R3 low level on source 1, R8 priority against source 3
    cur_req = "R8";
    mode[3:2] = 2'b11;
    pin[3] = 1'b1;
    cyc(8);
    check("R3", vec, 8'h0B);
    mode[3:2] = 2'b00;
    cyc(2);
    clr[1] = 1'b1;
    cyc(1);
    clr[1] = 1'b0;
    cyc(1);
    check("R8", vec, 8'h1B);
    clr[3] = 1'b1;
    pin[3] = 1'b0;
    cyc(1);
    clr[3] = 1'b0;
    cyc(8);
    clr = 4'hF;
    cyc(1);
    clr = 4'h0;
    cyc(1);
    check("R8", {7'd0, irq}, 8'h00);

    // R4, R7, R11: both edges on source 2 while disabled
    cur_req = "R7";
    mode[5:4] = 2'b10;
    en[2] = 1'b0;
    evt_cnt2 = 0;
    pin[2] = 1'b1;
    cyc(3);
    pin[2] = 1'b0;
    cyc(6);
    check("R11", 8'(evt_cnt2), 8'd2);
    check("R7", {7'd0, irq}, 8'h00);
    en[2] = 1'b1;
    cyc(1);
    check("R7", {7'd0, irq}, 8'h00);

    // R6: new edge and clear in the same cycle
    cur_req = "R6";
    pin[2] = 1'b1;
    cyc(6);
    check("R4", vec, 8'h13);
    pin[2] = 1'b0;
    cyc(3);
    clr[2] = 1'b1;
    cyc(1);
    clr[2] = 1'b0;
    check("R6", {irq, vec[6:0]}, 8'h93);
    cyc(2);
    clr[2] = 1'b1;
    cyc(1);
    clr[2] = 1'b0;
    cyc(1);
    check("R6", {7'd0, irq}, 8'h00);
    mode[5:4] = 2'b00;

    // R10 filter widths at each rate
    filt_case(2'b00, 1, 0);
    filt_case(2'b00, 2, 1);
    filt_case(2'b01, 15, 0);
    filt_case(2'b01, 32, 1);
    filt_case(2'b10, 63, 0);
    filt_case(2'b10, 128, 1);

    // mixed random traffic, model compared
    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      if (k % 250 == 0) begin
        mode = 8'($urandom);
        fsel = 2'($urandom);
        en = 4'($urandom);
      end
      for (int b = 0; b < 4; b++) if ($urandom_range(0, 9) == 0) pin[b] = ~pin[b];
      clr = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      cyc(1);
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 190000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule